// File: doc/BRIEF.md
# Debug Abort Entry Sequencer

This block models the part of a processor's status unit that takes a debug exception while the core runs monitor-mode debugging. Break requests come in from the instruction-address comparators, the software breakpoint instruction, the data-address comparators, an external debug break line and the trace buffer's full signal. When a request is accepted, the block writes the abort-mode status word and saves the previous status word. It also loads the link register and latches the method-of-entry code. It sets the debug fault flag, turns the trace buffer off and presents the abort vector to fetch. All of this happens in a single clock edge.

The external and trace-full requests must not disturb a handler that is already running in abort mode. While the status word's mode field reads abort, these two sources are recorded in sticky pending flags. When software leaves abort mode, by restoring the saved status or by writing the status register directly, the pending break is taken on the next edge. Taking any debug exception wipes every pending flag.

The fetch unit and the handler software are the users. Fetch redirects to `vecPc` when `excTaken` pulses. Software writes the status register through `srWrEn`/`srWrData` or restores it with `srRestore`.

Top module: `dbg_exc_sequencer`

## Requirements
- R1: While reset is asserted the status register reads 0x0000_00D3. The saved status, link register, vector PC and entry code read zero, and the fault flag, trace-off and excTaken read 0.
- R2: An instruction, software, external or trace-full break is taken as a prefetch abort. The vector PC becomes 0x0C and the link register becomes faultPc + 4, with modulo 2^32 wrap.
- R3: A data break is taken as a data abort. The vector PC becomes 0x10 and the link register becomes nextPc + 4.
- R4: On an accepted break, the saved status receives the previous status word. In the new status word bits [4:0] = 5'b10111, bit 5 = 0, bit 7 = 1, and bit 6 and bits [31:8] are kept.
- R5: On an accepted break the fault flag and trace-off outputs are set and stay set until reset. The entry code is written as follows: instruction 3'b001, data 3'b010, software 3'b011, external 3'b100, trace-full 3'b101.
- R6: When several requests are eligible in one cycle, only one is taken, in this order: data, instruction, software, external, trace-full.
- R7: No break is taken and no output changes on account of break requests while monitorMode is 0.
- R8: While the status mode field is 5'b10111, an external or trace-full request is not taken but is held pending.
- R9: When abort mode is left by a restore or a direct write while a break is pending, that break is taken on the clock edge after the one that left abort mode. An external break is taken before a trace-full break.
- R10: Taking any break clears all pending flags. A status write that keeps the mode at abort does not release a pending break.
- R11: All outputs are registered and change on the clock edge that samples the request. excTaken is high for exactly the cycles following an accepted edge.
- R12: An accepted break takes precedence over a same-cycle status write or restore. Otherwise, srRestore loads the saved status and srWrEn loads srWrData, and restore takes precedence over write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| monitorMode | input | 1 | Monitor-mode debugging enabled |
| instBrkReq | input | 1 | Instruction address breakpoint hit |
| swBrkReq | input | 1 | Software breakpoint instruction reached |
| dataBrkReq | input | 1 | Data address breakpoint hit |
| extBrkReq | input | 1 | External debug break request |
| traceFullReq | input | 1 | Trace buffer full break request |
| faultPc | input | 32 | Address of the faulting instruction |
| nextPc | input | 32 | Address of the next instruction to execute |
| srWrEn | input | 1 | Direct status register write |
| srWrData | input | 32 | Data for the direct status write |
| srRestore | input | 1 | Restore status from saved status |
| statusReg | output | 32 | Current status register |
| savedStatus | output | 32 | Saved abort status register |
| linkReg | output | 32 | Abort link register |
| fsrDbgFlag | output | 1 | Debug fault status flag |
| entryCode | output | 3 | Method-of-entry code |
| traceOff | output | 1 | Trace buffer disable |
| vecPc | output | 32 | Abort vector presented to fetch |
| excTaken | output | 1 | Pulse: a break was accepted on the last edge |

## Verification
The hardest case to reach is a pending break that is released on exit from abort mode. The core must first be driven into abort mode by a real break. External and trace-full requests are then raised while the mode field reads abort. Finally the mode must be left by one of the two exit paths. The bench builds this chain by hand for both exits. It checks the cycle after the exit edge as well as the exit edge itself. It also checks two cases that must not release the pending break: a write that keeps the mode at abort, and an intervening break that clears the pending flags.

// File: rtl/dbgx_pkg.sv
package dbgx_pkg;
  localparam int XLEN   = 32;
  localparam int CODE_W = 3;
  localparam int NPOST  = 2;   // postponed sources: [0] external, [1] trace-full

  localparam logic [4:0] ABORT_MODE = 5'b10111;

  typedef enum logic [CODE_W-1:0] {
    EC_NONE  = 3'b000,
    EC_IBRK  = 3'b001,
    EC_DBRK  = 3'b010,
    EC_SWBRK = 3'b011,
    EC_EXT   = 3'b100,
    EC_TRACE = 3'b101
  } entryCode_e;

  typedef struct packed {
    logic       take;
    logic       isData;
    entryCode_e code;
    logic       doRestore;
    logic       doWrite;
  } dpStrobe_t;
endpackage

// File: rtl/dbgx_ctrl.sv
module dbgx_ctrl
  import dbgx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      monitorMode,
  input  logic      instBrkReq,
  input  logic      swBrkReq,
  input  logic      dataBrkReq,
  input  logic      extBrkReq,
  input  logic      traceFullReq,
  input  logic      srWrEn,
  input  logic      srRestore,
  input  logic      abortMode,
  output dpStrobe_t strobe
);
  logic [NPOST-1:0] pendQ;
  logic [NPOST-1:0] postReq;
  logic [NPOST-1:0] postAvail;
  logic [NPOST-1:0] pendNext;

  assign postReq = {traceFullReq, extBrkReq};

  // A postponed source is eligible outside abort mode, live or pending.
  genvar g;
  generate
    for (g = 0; g < NPOST; g++) begin : gPost
      assign postAvail[g] = ~abortMode & (postReq[g] | pendQ[g]);
      always_comb begin
        if (strobe.take)
          pendNext[g] = 1'b0;
        else if (monitorMode && abortMode)
          pendNext[g] = pendQ[g] | postReq[g];
        else
          pendNext[g] = pendQ[g];
      end
    end
  endgenerate

  always_comb begin
    strobe = '0;
    strobe.code = EC_NONE;
    if (monitorMode) begin
      if (dataBrkReq) begin
        strobe.take = 1'b1; strobe.isData = 1'b1; strobe.code = EC_DBRK;
      end else if (instBrkReq) begin
        strobe.take = 1'b1; strobe.code = EC_IBRK;
      end else if (swBrkReq) begin
        strobe.take = 1'b1; strobe.code = EC_SWBRK;
      end else if (postAvail[0]) begin
        strobe.take = 1'b1; strobe.code = EC_EXT;
      end else if (postAvail[1]) begin
        strobe.take = 1'b1; strobe.code = EC_TRACE;
      end
    end
    strobe.doRestore = srRestore & ~strobe.take;
    strobe.doWrite   = srWrEn & ~srRestore & ~strobe.take;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendNext;
  end
endmodule

// File: rtl/dbgx_datapath.sv
module dbgx_datapath
  import dbgx_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_SR = 32'h0000_00D3,
  parameter logic [XLEN-1:0] PF_VEC   = 32'h0000_000C,
  parameter logic [XLEN-1:0] DA_VEC   = 32'h0000_0010
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [XLEN-1:0]   faultPc,
  input  logic [XLEN-1:0]   nextPc,
  input  logic [XLEN-1:0]   srWrData,
  output logic [XLEN-1:0]   statusReg,
  output logic [XLEN-1:0]   savedStatus,
  output logic [XLEN-1:0]   linkReg,
  output logic              fsrDbgFlag,
  output logic [CODE_W-1:0] entryCode,
  output logic              traceOff,
  output logic [XLEN-1:0]   vecPc,
  output logic              excTaken,
  output logic              abortMode
);
  localparam logic [XLEN-1:0] LINK_OFS = XLEN'(4);

  logic [XLEN-1:0] abortSr;

  assign abortSr   = {statusReg[XLEN-1:8], 1'b1, statusReg[6], 1'b0, ABORT_MODE};
  assign abortMode = (statusReg[4:0] == ABORT_MODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg   <= RESET_SR;
      savedStatus <= '0;
      linkReg     <= '0;
      fsrDbgFlag  <= 1'b0;
      entryCode   <= EC_NONE;
      traceOff    <= 1'b0;
      vecPc       <= '0;
      excTaken    <= 1'b0;
    end else begin
      excTaken <= strobe.take;
      if (strobe.take) begin
        statusReg   <= abortSr;
        savedStatus <= statusReg;
        linkReg     <= (strobe.isData ? nextPc : faultPc) + LINK_OFS;
        vecPc       <= strobe.isData ? DA_VEC : PF_VEC;
        entryCode   <= strobe.code;
        fsrDbgFlag  <= 1'b1;
        traceOff    <= 1'b1;
      end else if (strobe.doRestore) begin
        statusReg <= savedStatus;
      end else if (strobe.doWrite) begin
        statusReg <= srWrData;
      end
    end
  end
endmodule

// File: rtl/dbg_exc_sequencer.sv
module dbg_exc_sequencer
  import dbgx_pkg::*;
#(
  parameter logic [31:0] RESET_SR = 32'h0000_00D3,
  parameter logic [31:0] PF_VEC   = 32'h0000_000C,
  parameter logic [31:0] DA_VEC   = 32'h0000_0010
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        monitorMode,
  input  logic        instBrkReq,
  input  logic        swBrkReq,
  input  logic        dataBrkReq,
  input  logic        extBrkReq,
  input  logic        traceFullReq,
  input  logic [31:0] faultPc,
  input  logic [31:0] nextPc,
  input  logic        srWrEn,
  input  logic [31:0] srWrData,
  input  logic        srRestore,
  output logic [31:0] statusReg,
  output logic [31:0] savedStatus,
  output logic [31:0] linkReg,
  output logic        fsrDbgFlag,
  output logic [2:0]  entryCode,
  output logic        traceOff,
  output logic [31:0] vecPc,
  output logic        excTaken
);
  dpStrobe_t strobe;
  logic      abortMode;

  dbgx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .monitorMode(monitorMode),
    .instBrkReq(instBrkReq), .swBrkReq(swBrkReq), .dataBrkReq(dataBrkReq),
    .extBrkReq(extBrkReq), .traceFullReq(traceFullReq),
    .srWrEn(srWrEn), .srRestore(srRestore), .abortMode(abortMode),
    .strobe(strobe)
  );

  dbgx_datapath #(.RESET_SR(RESET_SR), .PF_VEC(PF_VEC), .DA_VEC(DA_VEC)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .faultPc(faultPc), .nextPc(nextPc), .srWrData(srWrData),
    .statusReg(statusReg), .savedStatus(savedStatus), .linkReg(linkReg),
    .fsrDbgFlag(fsrDbgFlag), .entryCode(entryCode), .traceOff(traceOff),
    .vecPc(vecPc), .excTaken(excTaken), .abortMode(abortMode)
  );
endmodule

// File: rtl/dbgx_checker.sv
module dbgx_checker (
  input logic        clk,
  input logic        rstN,
  input logic        monitorMode,
  input logic        instBrkReq,
  input logic        swBrkReq,
  input logic        dataBrkReq,
  input logic        extBrkReq,
  input logic        traceFullReq,
  input logic [31:0] faultPc,
  input logic [31:0] nextPc,
  input logic        srWrEn,
  input logic [31:0] srWrData,
  input logic        srRestore,
  input logic [31:0] statusReg,
  input logic [31:0] savedStatus,
  input logic [31:0] linkReg,
  input logic        fsrDbgFlag,
  input logic [2:0]  entryCode,
  input logic        traceOff,
  input logic [31:0] vecPc,
  input logic        excTaken
);
  a_r4_abort_status: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> (statusReg[4:0] == 5'b10111) && statusReg[7] && !statusReg[5]
                 && (statusReg[6] == $past(statusReg[6])));

  a_r4_saved_copy: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> savedStatus == $past(statusReg));

  a_r3_data_vector: assert property (@(posedge clk) disable iff (!rstN)
    (excTaken && $past(dataBrkReq)) |-> (vecPc == 32'h10) && (linkReg == $past(nextPc) + 32'd4));

  a_r2_prefetch_vector: assert property (@(posedge clk) disable iff (!rstN)
    (excTaken && !$past(dataBrkReq)) |-> (vecPc == 32'hC) && (linkReg == $past(faultPc) + 32'd4));

  a_r5_flags_set: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> fsrDbgFlag && traceOff);

  a_r7_monitor_off: assert property (@(posedge clk) disable iff (!rstN)
    !monitorMode |=> !excTaken);

  a_r6_data_first: assert property (@(posedge clk) disable iff (!rstN)
    (monitorMode && dataBrkReq) |=> excTaken && (entryCode == 3'b010));
endmodule

bind dbg_exc_sequencer dbgx_checker uChk (.*);

// File: tb/tb_dbg_exc_sequencer.sv
module tb_dbg_exc_sequencer;
  logic        clk = 1'b0;
  logic        rstN;
  logic        monitorMode, instBrkReq, swBrkReq, dataBrkReq, extBrkReq, traceFullReq;
  logic [31:0] faultPc, nextPc, srWrData;
  logic        srWrEn, srRestore;
  logic [31:0] statusReg, savedStatus, linkReg, vecPc;
  logic        fsrDbgFlag, traceOff, excTaken;
  logic [2:0]  entryCode;

  int  nRun  = 0;
  int  nFail = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dbg_exc_sequencer dut (.*);

  // {data, inst, sw, ext, trace} requests, expected code, expected taken
  localparam logic [8:0] VECS [10] = '{
    9'b01000_001_1, 9'b00100_011_1, 9'b10000_010_1, 9'b11100_010_1,
    9'b01100_001_1, 9'b00010_100_1, 9'b00001_101_1, 9'b00011_100_1,
    9'b00110_011_1, 9'b00000_000_0
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clearReqs();
    instBrkReq = 0; swBrkReq = 0; dataBrkReq = 0; extBrkReq = 0; traceFullReq = 0;
    srWrEn = 0; srRestore = 0;
  endtask

  task automatic setSr(logic [31:0] v);
    srWrEn = 1; srWrData = v; tick(); srWrEn = 0;
  endtask

  initial begin
    rstN = 0; monitorMode = 0; faultPc = 32'h1000; nextPc = 32'h2000; srWrData = 0;
    clearReqs();
    repeat (3) tick();
    // R1 reset state
    chk("R1 status", statusReg, 32'hD3);
    chk("R1 saved", savedStatus, 0);
    chk("R1 link", linkReg, 0);
    chk("R1 vec", vecPc, 0);
    chk("R1 flags", {29'd0, fsrDbgFlag, traceOff, excTaken}, 0);
    chk("R1 code", {29'd0, entryCode}, 0);
    rstN = 1; monitorMode = 1;
    tick();

    // Table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 10; i++) begin
      logic [8:0] v;
      v = VECS[i];
      setSr(32'h73);
      {dataBrkReq, instBrkReq, swBrkReq, extBrkReq, traceFullReq} = v[8:4];
      tick();
      clearReqs();
      chk("R6 taken", {31'd0, excTaken}, {31'd0, v[0]});
      if (v[0]) begin
        chk("R6 R5 code", {29'd0, entryCode}, {29'd0, v[3:1]});
        chk("R2 R3 vector", vecPc, (v[3:1] == 3'b010) ? 32'h10 : 32'hC);
        chk("R2 R3 link", linkReg, (v[3:1] == 3'b010) ? 32'h2004 : 32'h1004);
        chk("R4 status", statusReg, 32'hD7);
        chk("R4 saved", savedStatus, 32'h73);
        chk("R5 flags", {30'd0, fsrDbgFlag, traceOff}, 32'h3);
      end else begin
        chk("R6 idle status", statusReg, 32'h73);
      end
      tick();
      chk("R11 pulse ends", {31'd0, excTaken}, 0);
    end

    // R7 monitor mode off
    monitorMode = 0; setSr(32'h73);
    instBrkReq = 1; dataBrkReq = 1; extBrkReq = 1; tick(); clearReqs();
    chk("R7 no take", {31'd0, excTaken}, 0);
    chk("R7 status kept", statusReg, 32'h73);
    monitorMode = 1; tick();
    chk("R7 nothing pended", {31'd0, excTaken}, 0);

    // R2 wrap, R3 other address
    faultPc = 32'hFFFF_FFFC; instBrkReq = 1; tick(); clearReqs();
    chk("R2 link wrap", linkReg, 32'h0);
    setSr(32'h73);
    nextPc = 32'h8000_0000; dataBrkReq = 1; tick(); clearReqs();
    chk("R3 link", linkReg, 32'h8000_0004);
    faultPc = 32'h1000; nextPc = 32'h2000;

    // R11 back-to-back: held request, second take saves abort status
    setSr(32'h73);
    instBrkReq = 1; tick();
    chk("R11 first", {31'd0, excTaken}, 1);
    tick(); clearReqs();
    chk("R11 second", {31'd0, excTaken}, 1);
    chk("R4 saved abort", savedStatus, 32'hD7);

    // R8 R9 R10: pending released by a direct write
    setSr(32'h73);
    instBrkReq = 1; tick(); clearReqs();
    extBrkReq = 1; tick(); clearReqs();
    chk("R8 ext held", {31'd0, excTaken}, 0);
    chk("R8 code kept", {29'd0, entryCode}, 1);
    traceFullReq = 1; tick(); clearReqs();
    chk("R8 trace held", {31'd0, excTaken}, 0);
    setSr(32'h73);
    chk("R9 exit edge", {31'd0, excTaken}, 0);
    chk("R9 exit status", statusReg, 32'h73);
    tick();
    chk("R9 fired", {31'd0, excTaken}, 1);
    chk("R9 ext first", {29'd0, entryCode}, 3'b100);
    setSr(32'h73); tick();
    chk("R10 trace cleared", {31'd0, excTaken}, 0);

    // R9 release by restore
    swBrkReq = 1; tick(); clearReqs();
    traceFullReq = 1; tick(); clearReqs();
    srRestore = 1; tick(); clearReqs();
    chk("R12 restore", statusReg, 32'h73);
    chk("R9 restore edge", {31'd0, excTaken}, 0);
    tick();
    chk("R9 restore fired", {31'd0, excTaken}, 1);
    chk("R9 trace code", {29'd0, entryCode}, 3'b101);

    // R10 write staying in abort, then a break clears pending
    extBrkReq = 1; tick(); clearReqs();
    setSr(32'h97); tick();
    chk("R10 stay abort", {31'd0, excTaken}, 0);
    instBrkReq = 1; tick(); clearReqs();
    chk("R10 inst in abort", {29'd0, entryCode}, 1);
    setSr(32'h73); tick();
    chk("R10 pend wiped", {31'd0, excTaken}, 0);

    // R12 break wins over write
    instBrkReq = 1; srWrEn = 1; srWrData = 32'h1F; tick(); clearReqs();
    chk("R12 break wins", statusReg, 32'hD7);
    chk("R12 saved", savedStatus, 32'h73);
    srRestore = 1; srWrEn = 1; srWrData = 32'h1F; tick(); clearReqs();
    chk("R12 restore over write", statusReg, 32'h73);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule